// File: doc/BRIEF.md
# Multi-Parent Level-Sensitive Interrupt Aggregator

This block gathers up to 128 level-sensitive interrupt sources, grouped into one to four 32-bit words, and fans them out to several parent interrupt lines. Software controls the block through a small register bus. Each word has an enable register, a read-only status view of the live source levels, and a wake-enable register. Each parent line sees the shared words through a routing mask that is fixed at elaboration. The line is raised when a source is active, enabled and routed to that parent.

There is no acknowledge. A source stays pending for as long as its input level is high, so the handler clears the cause at the source. While the system is suspended and the block is built with wake capability, the wake-enable bits are merged into the effective enable set. When the system resumes, only the normal enable register applies again. Source bits that no parent routes are unused: they never reach any output and cannot be armed for wake.

Top module: `l2_irq_agg`

## Requirements
- R1: After reset, the enable register of word w holds slice w of FWD_MASK, every wake-enable register reads 0, and every bit of irq_o is 0.
- R2: Register word offsets: the enable register of word w is at 0x00+8w, its status register at 0x04+8w, and its wake-enable register at 0x20+4w. A read returns data in the same cycle on rdata_o, and a write takes effect at the clock edge where we_i is high.
- R3: A status read returns the current src_i bits of that word. Writes to a status offset change no register.
- R4: A write to an enable offset stores all 32 bits of wdata_i, and later reads return that value.
- R5: irq_o[p] is registered. One clock edge after the inputs are sampled, it equals the OR over all words w of src_i[w] & eff_en[w] & ROUTE_MASK[p][w]. ROUTE_MASK packs parent p, word w at bit (p*NUM_WORDS+w)*32.
- R6: A source bit whose routing mask bit is clear for parent p never raises irq_o[p], even when it is enabled and active.
- R7: Source bits that appear in no parent's routing mask never raise any output. Their wake-enable bits always read 0.
- R8: With CAN_WAKE=1 and suspend_i high, eff_en is the enable register ORed with the wake-enable register. Otherwise eff_en is the enable register alone, so clearing suspend_i brings back the saved enable set on the next edge.
- R9: A read from an unmapped or non-word-aligned offset returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_WORDS*32 | Level-sensitive source inputs, word w at bits [32w+31:32w] |
| suspend_i | input | 1 | System suspended; merges wake enables when CAN_WAKE=1 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| irq_o | output | NUM_PARENTS | Registered parent interrupt lines |

## Verification
The bench builds the block with two words, two parents and wake capability on. Parent 0 routes the low half of word 0 and byte 0 of word 1. Parent 1 routes the high half of word 0 and byte 1 of word 1. The reset forward mask is 0x3 on word 0. This leaves the top 16 bits of word 1 routed to no parent, so unused-bit suppression and wake-enable masking can be observed. With two words, offsets past the last word fall in the unmapped range. The nonzero reset enable is visible both on readback and as an interrupt raised without any write.

// File: rtl/l2_irq_pkg.sv
package l2_irq_pkg;
  localparam int unsigned WORD_BITS = 32;
  localparam int unsigned REG_AW    = 6;
  localparam int unsigned WAKE_IDX  = 8;  // 0x20 >> 2
  localparam int unsigned MAX_WORDS = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_STAT,
    SEL_WAKE
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] word;
  } reg_dec_t;
endpackage

// File: rtl/l2_irq_decode.sv
module l2_irq_decode
  import l2_irq_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 1
) (
  input  logic [REG_AW-1:0] addr_i,
  output reg_dec_t          dec_o
);
  logic [REG_AW-3:0] idx;

  always_comb begin
    idx   = addr_i[REG_AW-1:2];
    dec_o = '{sel: SEL_NONE, word: 2'd0};
    if (addr_i[1:0] == 2'b00) begin
      if (idx < 4'(2 * NUM_WORDS)) begin
        dec_o.sel  = idx[0] ? SEL_STAT : SEL_EN;
        dec_o.word = idx[2:1];
      end else if (idx >= 4'(WAKE_IDX) && idx < 4'(WAKE_IDX + NUM_WORDS)) begin
        dec_o.sel  = SEL_WAKE;
        dec_o.word = idx[1:0];
      end
    end
  end
endmodule

// File: rtl/l2_irq_regs.sv
module l2_irq_regs
  import l2_irq_pkg::*;
#(
  parameter int unsigned                        NUM_WORDS = 1,
  parameter logic [NUM_WORDS*WORD_BITS-1:0]     FWD_MASK  = '0,
  parameter logic [NUM_WORDS*WORD_BITS-1:0]     USED_MASK = '1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  reg_dec_t                         dec_i,
  input  logic [WORD_BITS-1:0]             wdata_i,
  input  logic [NUM_WORDS*WORD_BITS-1:0]   src_i,
  output logic [WORD_BITS-1:0]             rdata_o,
  output logic [NUM_WORDS*WORD_BITS-1:0]   en_o,
  output logic [NUM_WORDS*WORD_BITS-1:0]   wake_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam logic [WORD_BITS-1:0] FWD  = FWD_MASK[w*WORD_BITS +: WORD_BITS];
    localparam logic [WORD_BITS-1:0] USED = USED_MASK[w*WORD_BITS +: WORD_BITS];

    logic [WORD_BITS-1:0] en_q;
    logic [WORD_BITS-1:0] wake_q;
    logic                 hit;

    assign hit = we_i && (dec_i.word == 2'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= FWD;
        wake_q <= '0;
      end else if (hit) begin
        if (dec_i.sel == SEL_EN)   en_q   <= wdata_i;
        // unused sources cannot be wake sources
        if (dec_i.sel == SEL_WAKE) wake_q <= wdata_i & USED;
      end
    end

    assign en_o[w*WORD_BITS +: WORD_BITS]   = en_q;
    assign wake_o[w*WORD_BITS +: WORD_BITS] = wake_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (dec_i.word == 2'(w)) begin
        unique case (dec_i.sel)
          SEL_EN:   rdata_o = en_o[w*WORD_BITS +: WORD_BITS];
          SEL_STAT: rdata_o = src_i[w*WORD_BITS +: WORD_BITS];
          SEL_WAKE: rdata_o = wake_o[w*WORD_BITS +: WORD_BITS];
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/l2_irq_route.sv
module l2_irq_route
  import l2_irq_pkg::*;
#(
  parameter int unsigned                    NUM_WORDS = 1,
  parameter logic [NUM_WORDS*WORD_BITS-1:0] ROUTE     = '1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WORDS*WORD_BITS-1:0] src_i,
  input  logic [NUM_WORDS*WORD_BITS-1:0] eff_en_i,
  output logic                           irq_o
);
  logic hit;
  assign hit = |(src_i & eff_en_i & ROUTE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= hit;
  end
endmodule

// File: rtl/l2_irq_agg.sv
module l2_irq_agg
  import l2_irq_pkg::*;
#(
  parameter int unsigned                                  NUM_WORDS   = 1,
  parameter int unsigned                                  NUM_PARENTS = 1,
  parameter bit                                           CAN_WAKE    = 1'b1,
  parameter logic [NUM_PARENTS*NUM_WORDS*WORD_BITS-1:0]   ROUTE_MASK  = '1,
  parameter logic [NUM_WORDS*WORD_BITS-1:0]               FWD_MASK    = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_WORDS*WORD_BITS-1:0] src_i,
  input  logic                           suspend_i,
  input  logic                           we_i,
  input  logic [REG_AW-1:0]              addr_i,
  input  logic [WORD_BITS-1:0]           wdata_i,
  output logic [WORD_BITS-1:0]           rdata_o,
  output logic [NUM_PARENTS-1:0]         irq_o
);
  localparam int unsigned SRC_W = NUM_WORDS * WORD_BITS;

  function automatic logic [SRC_W-1:0] calc_used();
    logic [SRC_W-1:0] u;
    u = '0;
    for (int p = 0; p < NUM_PARENTS; p++) u |= ROUTE_MASK[p*SRC_W +: SRC_W];
    return u;
  endfunction

  localparam logic [SRC_W-1:0] USED_MASK = calc_used();

  reg_dec_t         dec;
  logic [SRC_W-1:0] en_w;
  logic [SRC_W-1:0] wake_w;
  logic [SRC_W-1:0] eff_en;
  logic             wake_act;

  l2_irq_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  l2_irq_regs #(
    .NUM_WORDS (NUM_WORDS),
    .FWD_MASK  (FWD_MASK),
    .USED_MASK (USED_MASK)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .dec_i   (dec),
    .wdata_i (wdata_i),
    .src_i   (src_i),
    .rdata_o (rdata_o),
    .en_o    (en_w),
    .wake_o  (wake_w)
  );

  assign wake_act = CAN_WAKE && suspend_i;
  assign eff_en   = wake_act ? (en_w | wake_w) : en_w;

  for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_parent
    l2_irq_route #(
      .NUM_WORDS (NUM_WORDS),
      .ROUTE     (ROUTE_MASK[p*SRC_W +: SRC_W])
    ) u_route (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i),
      .eff_en_i (eff_en),
      .irq_o    (irq_o[p])
    );
  end
endmodule

// File: rtl/l2_irq_agg_chk.sv
module l2_irq_agg_chk #(
  parameter int unsigned                         NUM_WORDS   = 1,
  parameter int unsigned                         NUM_PARENTS = 1,
  parameter bit                                  CAN_WAKE    = 1'b1,
  parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0] ROUTE_MASK  = '1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_WORDS*32-1:0]   src_i,
  input logic                      suspend_i,
  input logic                      we_i,
  input logic [5:0]                addr_i,
  input logic [31:0]               wdata_i,
  input logic [31:0]               rdata_o,
  input logic [NUM_PARENTS-1:0]    irq_o,
  input logic [NUM_WORDS*32-1:0]   en_i,
  input logic [NUM_WORDS*32-1:0]   wake_i
);
  localparam int unsigned SW = NUM_WORDS * 32;

  logic             past_ok;
  logic [SW-1:0]    eff;
  logic [SW-1:0]    any_route;
  logic [NUM_PARENTS-1:0] hit;
  logic             mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign eff = (CAN_WAKE && suspend_i) ? (en_i | wake_i) : en_i;

  always_comb begin
    any_route = '0;
    for (int p = 0; p < NUM_PARENTS; p++) any_route |= ROUTE_MASK[p*SW +: SW];
  end

  for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_p
    assign hit[p] = |(src_i & eff & ROUTE_MASK[p*SW +: SW]);
    // R5
    irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> irq_o[p] == $past(hit[p]));
  end

  assign mapped = (addr_i[1:0] == 2'b00) &&
                  ((32'(addr_i[5:2]) < 2 * NUM_WORDS) ||
                   (32'(addr_i[5:2]) >= 8 && 32'(addr_i[5:2]) < 8 + NUM_WORDS));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    // R4
    en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 6'(8 * w)) |=> en_i[w*32 +: 32] == $past(wdata_i));
    // R3
    stat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 6'(8 * w + 4)) |=> ($stable(en_i) && $stable(wake_i)));
  end

  // R7
  wake_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i & ~any_route) == '0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> rdata_o == 32'h0);

  // R9
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mapped) |=> ($stable(en_i) && $stable(wake_i)));
endmodule

bind l2_irq_agg l2_irq_agg_chk #(
  .NUM_WORDS   (NUM_WORDS),
  .NUM_PARENTS (NUM_PARENTS),
  .CAN_WAKE    (CAN_WAKE),
  .ROUTE_MASK  (ROUTE_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .suspend_i (suspend_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .en_i      (en_w),
  .wake_i    (wake_w)
);

// File: tb/sim_l2_irq_agg.sv
`timescale 1ns/1ps
module sim_l2_irq_agg;
  localparam int unsigned NW = 2;
  localparam int unsigned NP = 2;
  // {p1w1, p1w0, p0w1, p0w0}
  localparam logic [NP*NW*32-1:0] ROUTE = {32'h0000FF00, 32'hFFFF0000, 32'h000000FF, 32'h0000FFFF};
  localparam logic [NW*32-1:0]    FWD   = {32'h00000000, 32'h00000003};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NW*32-1:0]  src_i = '0;
  logic              suspend_i = 1'b0;
  logic              we_i = 1'b0;
  logic [5:0]        addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NP-1:0]     irq_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  l2_irq_agg #(
    .NUM_WORDS (NW), .NUM_PARENTS (NP), .CAN_WAKE (1'b1),
    .ROUTE_MASK (ROUTE), .FWD_MASK (FWD)
  ) u0 (
    .clk_i (clk_i), .rst_ni (rst_ni), .src_i (src_i), .suspend_i (suspend_i),
    .we_i (we_i), .addr_i (addr_i), .wdata_i (wdata_i),
    .rdata_o (rdata_o), .irq_o (irq_o)
  );

  typedef struct packed {
    logic [31:0] en0, en1, wk0, wk1, s0, s1;
    logic        susp;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h00000001, 32'h0, 32'h0, 32'h0, 32'h00000001, 32'h0, 1'b0, 2'b01},
    '{32'h00010000, 32'h0, 32'h0, 32'h0, 32'h00010000, 32'h0, 1'b0, 2'b10},
    '{32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 1'b0, 2'b00},
    '{32'h0, 32'h00000100, 32'h0, 32'h0, 32'h0, 32'h00000100, 1'b0, 2'b10},
    '{32'h0, 32'h00000001, 32'h0, 32'h0, 32'h0, 32'h00000001, 1'b0, 2'b01},
    '{32'h0, 32'hFFFF0000, 32'h0, 32'h0, 32'h0, 32'hFFFF0000, 1'b0, 2'b00},
    '{32'h0, 32'h0, 32'h00000001, 32'h0, 32'h00000001, 32'h0, 1'b0, 2'b00},
    '{32'h0, 32'h0, 32'h00000001, 32'h0, 32'h00000001, 32'h0, 1'b1, 2'b01},
    '{32'h0, 32'h0, 32'h0, 32'h00008000, 32'h0, 32'h00008000, 1'b1, 2'b10},
    '{32'h0, 32'h0, 32'h0, 32'hFFFF0000, 32'h0, 32'hFFFF0000, 1'b1, 2'b00},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 2'b11}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    rd(6'h00, v); check("R1 en0 reset", v, 32'h3);
    rd(6'h08, v); check("R1 en1 reset", v, 32'h0);
    rd(6'h20, v); check("R1 wake0 reset", v, 32'h0);
    rd(6'h24, v); check("R1 wake1 reset", v, 32'h0);
    // R1 forward mask active without writes; R5 exactly one edge of latency
    @(negedge clk_i); src_i = 64'h1;
    #1 check("R5 no change before edge", 32'(irq_o), 32'h0);
    @(negedge clk_i);
    check("R1 R5 fwd mask raises p0", 32'(irq_o), 32'h1);

    // R3 status reads live levels
    src_i = {32'hA5A50000, 32'h0000C3C3};
    rd(6'h04, v); check("R3 status0 live", v, 32'h0000C3C3);
    rd(6'h0C, v); check("R2 R3 status1 live", v, 32'hA5A50000);
    // R3 status write ignored
    wr(6'h04, 32'hDEADBEEF);
    rd(6'h00, v); check("R3 en0 after status write", v, 32'h3);
    rd(6'h04, v); check("R3 status0 after write", v, 32'h0000C3C3);
    src_i = '0;

    // R4 enable write/readback; R2 layout
    wr(6'h08, 32'h12345678);
    rd(6'h08, v); check("R2 R4 en1 readback", v, 32'h12345678);
    rd(6'h00, v); check("R4 en0 untouched", v, 32'h3);
    wr(6'h24, 32'h0F0F0F0F);
    rd(6'h24, v); check("R2 R7 wake1 used bits only", v, 32'h00000F0F);

    // R9 unmapped and misaligned
    rd(6'h10, v); check("R9 unmapped 0x10", v, 32'h0);
    rd(6'h3C, v); check("R9 unmapped 0x3C", v, 32'h0);
    rd(6'h01, v); check("R9 misaligned 0x01", v, 32'h0);
    wr(6'h10, 32'hFFFFFFFF);
    wr(6'h02, 32'hFFFFFFFF);
    rd(6'h00, v); check("R9 en0 after bad writes", v, 32'h3);
    rd(6'h08, v); check("R9 en1 after bad writes", v, 32'h12345678);

    // R5 R6 R7 R8 table
    for (int i = 0; i < NV; i++) begin
      wr(6'h00, VECS[i].en0);
      wr(6'h08, VECS[i].en1);
      wr(6'h20, VECS[i].wk0);
      wr(6'h24, VECS[i].wk1);
      @(negedge clk_i);
      src_i = {VECS[i].s1, VECS[i].s0};
      suspend_i = VECS[i].susp;
      @(negedge clk_i);
      check($sformatf("R5 R6 R7 R8 vector %0d", i), 32'(irq_o), 32'(VECS[i].exp));
    end
    rd(6'h24, v); check("R7 unused wake bits read 0", v, 32'h0);

    // R8 resume restores normal enable
    wr(6'h00, 32'h0);
    wr(6'h08, 32'h0);
    wr(6'h20, 32'h00000002);
    @(negedge clk_i); src_i = {32'h0, 32'h2}; suspend_i = 1'b1;
    @(negedge clk_i); check("R8 wake merge in suspend", 32'(irq_o), 32'h1);
    suspend_i = 1'b0;
    @(negedge clk_i); check("R8 resume drops wake", 32'(irq_o), 32'h0);
    rd(6'h00, v); check("R8 en0 kept across suspend", v, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule